// File: doc/BRIEF.md
# Serial Packet Output Serializer

This block turns a stream of packet bytes into a one-bit serial output that advances on the interface clock. Bytes arrive on a valid/ready port, each tagged with flags that say whether it opens or closes a packet. Four bytes are gathered into a staged quadlet. Once a quadlet is staged and the host enable is high, the quadlet moves into a shifter and is sent one bit per clock. A further staged quadlet follows with no gap.

A sync output shows where packets begin or end. Configuration selects which byte it marks: the first byte of a packet, the last byte, or none. It also selects whether sync covers only the first bit time of that byte or all eight, and whether each byte leaves least or most significant bit first. The host enable takes effect only between quadlets. If enable changes while a quadlet is partway out, the change waits for the quadlet to finish and a sticky error flag is raised.

Top module: `ser_tx`

## Requirements
- R1: While reset is held and on the first cycle after it, ser_d=0, ser_sync=0, data_avail=0, in_ready=1 and proto_err=0.
- R2: A byte is taken on a clock edge where in_valid and in_ready are both high. in_ready is low and data_avail is high exactly when four bytes are staged. A staged quadlet stays staged while tx_en is low.
- R3: When the shifter is idle at a clock edge where tx_en is high and a quadlet is staged, that quadlet enters the shifter. Its first bit appears on ser_d after the next edge.
- R4: The bytes of a quadlet leave in the order they were taken. Within a byte, cfg_lsb_first=0 sends bit 7 first and cfg_lsb_first=1 sends bit 0 first.
- R5: At the edge that sends bit 31 of a quadlet, if tx_en is high and another quadlet is staged, bit 0 of that quadlet follows on the next edge. No idle bit is inserted between bytes or between quadlets.
- R6: On any clock where no bit is sent, ser_d keeps its previous value and ser_sync is low.
- R7: tx_en is looked at only at a quadlet boundary, meaning while idle or at the edge that sends bit 31. A change at any other time does not alter the shifting.
- R8: proto_err becomes 1 at an edge that sends bit 0 to 30 of a quadlet if tx_en differs from its value at the previous edge. It then stays 1 until reset.
- R9: cfg_sync_mode encodes 2'b01 = mark the byte flagged first, 2'b10 = mark the byte flagged last, and 2'b00 or 2'b11 = never assert ser_sync.
- R10: With cfg_sync_full=1, ser_sync is high for all eight bit times of a marked byte. With cfg_sync_full=0, it is high only for that byte's first bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Offered byte |
| in_first | input | 1 | Byte opens a packet |
| in_last | input | 1 | Byte closes a packet |
| in_ready | output | 1 | Byte is accepted this edge if valid |
| tx_en | input | 1 | Host enable, acted on at quadlet boundaries |
| cfg_sync_mode | input | 2 | Sync marking selection (see R9) |
| cfg_sync_full | input | 1 | 1: sync spans the whole byte, 0: first bit only |
| cfg_lsb_first | input | 1 | 1: bit 0 of each byte goes first |
| ser_d | output | 1 | Serial data bit |
| ser_sync | output | 1 | Packet framing mark |
| data_avail | output | 1 | A full quadlet is staged |
| proto_err | output | 1 | Sticky: enable changed inside a quadlet |

## Verification
The hardest case to reach is an enable change that lands partway through a quadlet, as opposed to one that lands exactly on the bit-31 edge. From the outside, both look like the same change on tx_en. The stimulus starts a stream of several quadlets, waits a fixed number of clocks, and then drops or raises tx_en. Some of these offsets fall inside a quadlet and one falls on the boundary edge. The behavioural model follows the bit position cycle by cycle, so it predicts for each offset whether the line keeps shifting, stops, and raises the error flag.

// File: rtl/ser_tx_pkg.sv
// Shared widths and types for the serial packet output serializer.
package ser_tx_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    // Which byte of a packet the framing mark covers.
    typedef enum logic [1:0] {
        SYNC_NONE  = 2'b00,
        SYNC_FIRST = 2'b01,
        SYNC_LAST  = 2'b10,
        SYNC_RSVD  = 2'b11
    } sync_mode_e;

    // One staged byte together with its packet-position flags.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              first;
        logic              last;
    } lane_t;
endpackage

// File: rtl/ser_quad_stage.sv
// Gathers LANES incoming bytes into one staged quadlet.
// Assumes the consumer empties the whole stage in a single cycle (take),
// and only while the stage is full.
module ser_quad_stage
    import ser_tx_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  lane_t             in_lane,
    input  logic              take,
    output logic              in_ready,
    output logic              full,
    output lane_t [LANES-1:0] lanes
);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] fill_cnt;
    logic             accept;

    assign full     = (fill_cnt == CNT_W'(LANES));
    assign in_ready = !full;
    assign accept   = in_valid && in_ready;

    // Track how many lanes hold data; emptied whole when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_cnt <= '0;
        else if (take)
            fill_cnt <= '0;
        else if (accept)
            fill_cnt <= fill_cnt + 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Write the incoming byte into the lane it is due to occupy.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lanes[g] <= '0;
            else if (accept && fill_cnt == CNT_W'(g))
                lanes[g] <= in_lane;
        end
    end
endmodule

// File: rtl/ser_sync_gen.sv
// Decides whether the bit now being sent carries the framing mark.
// Purely combinational; the caller registers the result with the data bit.
module ser_sync_gen
    import ser_tx_pkg::*;
(
    input  logic [1:0]           mode,
    input  logic                 full_byte,
    input  lane_t                cur_lane,
    input  logic [BIT_IDX_W-1:0] bit_pos,
    output logic                 sync_req
);
    logic marked;

    // Pick the flag that the selected mode marks; reserved code marks nothing.
    always_comb begin
        unique case (sync_mode_e'(mode))
            SYNC_FIRST: marked = cur_lane.first;
            SYNC_LAST:  marked = cur_lane.last;
            default:    marked = 1'b0;
        endcase
    end

    assign sync_req = marked && (full_byte || bit_pos == '0);
endmodule

// File: rtl/ser_bit_engine.sv
// Shifts a staged quadlet out one bit per clock, with no gaps between
// quadlets, and samples the host enable only at quadlet boundaries.
// Assumes LANES is a power of two, so the bit counter splits into lane and bit.
module ser_bit_engine
    import ser_tx_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 avail,
    input  lane_t [LANES-1:0]    lanes_in,
    input  logic                 lsb_first,
    input  logic                 sync_req,
    output logic                 take,
    output logic                 shifting,
    output lane_t                cur_lane,
    output logic [BIT_IDX_W-1:0] bit_pos,
    output logic                 ser_d,
    output logic                 ser_sync,
    output logic                 proto_err
);
    localparam int QBITS = LANES * BYTE_W;
    localparam int CW    = $clog2(QBITS);
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [BIT_IDX_W-1:0] TOP_BIT = BIT_IDX_W'(BYTE_W - 1);

    logic              active;
    logic [CW-1:0]     cnt;
    lane_t [LANES-1:0] sh;
    logic              en_q;
    logic              last_bit;
    logic [LW-1:0]     lane_sel;
    logic              bit_val;

    assign last_bit = (cnt == CW'(QBITS - 1));
    assign take     = avail && tx_en && (!active || last_bit);
    assign shifting = active;
    assign lane_sel = LW'(cnt >> BIT_IDX_W);
    assign cur_lane = sh[lane_sel];
    assign bit_pos  = cnt[BIT_IDX_W-1:0];
    assign bit_val  = lsb_first ? cur_lane.data[bit_pos]
                                : cur_lane.data[TOP_BIT - bit_pos];

    // Busy flag: set on load, cleared after bit 31 unless a reload follows.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (take)
            active <= 1'b1;
        else if (active && last_bit)
            active <= 1'b0;
    end

    // Bit position within the quadlet, restarted on each load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (take)
            cnt <= '0;
        else if (active)
            cnt <= cnt + 1'b1;
    end

    // Shift register contents, copied from the stage on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else if (take)
            sh <= lanes_in;
    end

    // Output bit and mark; the data line holds while nothing is sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_d    <= 1'b0;
            ser_sync <= 1'b0;
        end else begin
            if (active)
                ser_d <= bit_val;
            ser_sync <= active && sync_req;
        end
    end

    // Remember enable and latch an error for changes inside a quadlet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (active && !last_bit && tx_en != en_q)
                proto_err <= 1'b1;
        end
    end
endmodule

// File: rtl/ser_tx.sv
// Serial packet output serializer top: byte stage, bit engine, sync marker.
// Assumes configuration inputs are steady while a quadlet is being sent.
module ser_tx
    import ser_tx_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_first,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       tx_en,
    input  logic [1:0] cfg_sync_mode,
    input  logic       cfg_sync_full,
    input  logic       cfg_lsb_first,
    output logic       ser_d,
    output logic       ser_sync,
    output logic       data_avail,
    output logic       proto_err
);
    lane_t                in_lane;
    lane_t [LANES-1:0]    staged;
    lane_t                cur_lane;
    logic                 take;
    logic                 shifting;
    logic                 sync_req;
    logic [BIT_IDX_W-1:0] bit_pos;

    assign in_lane = '{data: in_data, first: in_first, last: in_last};

    ser_quad_stage #(.LANES(LANES)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_lane  (in_lane),
        .take     (take),
        .in_ready (in_ready),
        .full     (data_avail),
        .lanes    (staged)
    );

    ser_bit_engine #(.LANES(LANES)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .avail     (data_avail),
        .lanes_in  (staged),
        .lsb_first (cfg_lsb_first),
        .sync_req  (sync_req),
        .take      (take),
        .shifting  (shifting),
        .cur_lane  (cur_lane),
        .bit_pos   (bit_pos),
        .ser_d     (ser_d),
        .ser_sync  (ser_sync),
        .proto_err (proto_err)
    );

    ser_sync_gen u_sync (
        .mode      (cfg_sync_mode),
        .full_byte (cfg_sync_full),
        .cur_lane  (cur_lane),
        .bit_pos   (bit_pos),
        .sync_req  (sync_req)
    );
endmodule

// File: rtl/ser_tx_chk.sv
// Temporal checks on the serializer's ports and its busy signal.
module ser_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_sync_mode,
    input logic       cfg_sync_full,
    input logic       tx_en,
    input logic       data_avail,
    input logic       ser_d,
    input logic       ser_sync,
    input logic       proto_err,
    input logic       shifting
);
    // R2: a staged quadlet is not consumed while enable is low
    assert_stage_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && !tx_en) |=> data_avail);

    // R6: nothing sent last cycle means a held line and no mark
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(shifting) |-> ($stable(ser_d) && !ser_sync));

    // R7: an idle engine with enable low does not start
    assert_idle_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tx_en) && !$past(shifting)) |-> !shifting);

    // R8: the error flag never clears outside reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(proto_err) |-> proto_err);

    // R9: no mark when marking is switched off or reserved
    assert_sync_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_sync_mode) == 2'b00 || $past(cfg_sync_mode) == 2'b11) |-> !ser_sync);

    // R10: a mark held two bit times needs whole-byte width
    assert_narrow_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sync && $past(ser_sync)) |-> $past(cfg_sync_full));
endmodule

bind ser_tx ser_tx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_sync_mode (cfg_sync_mode),
    .cfg_sync_full (cfg_sync_full),
    .tx_en         (tx_en),
    .data_avail    (data_avail),
    .ser_d         (ser_d),
    .ser_sync      (ser_sync),
    .proto_err     (proto_err),
    .shifting      (shifting)
);

// File: tb/sim_ser_tx.sv
`timescale 1ns/1ps
module sim_ser_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       tx_en = 1'b0;
    logic [1:0] cfg_sync_mode = 2'b01;
    logic       cfg_sync_full = 1'b1;
    logic       cfg_lsb_first = 1'b0;
    logic       ser_d, ser_sync, data_avail, proto_err;

    always #2.5 clk = ~clk;

    ser_tx u0 (.*);

    typedef struct packed { logic [7:0] d; logic f; logic l; } ent_t;
    ent_t  src[$];
    ent_t  fq[$];
    ent_t  sh[4];
    ent_t  cur;
    int    pos = 0;
    int    bp = 0;
    bit    act = 0, enp = 0, err = 0, md = 0, ms = 0, mark = 0, qfull = 0, acc = 0;
    int    vectors = 0, fails = 0;
    string tag = "R1";

    // Behavioural reference: staged byte queue plus a position in the quadlet.
    always @(posedge clk) begin
        if (!rst_n) begin
            fq.delete();
            act = 0; pos = 0; enp = 0; err = 0; md = 0; ms = 0;
        end else begin
            qfull = (fq.size() == 4);
            acc   = in_valid && (fq.size() < 4);
            if (act && pos != 31 && tx_en != enp) err = 1;
            if (act) begin
                cur  = sh[pos / 8];
                bp   = pos % 8;
                md   = cfg_lsb_first ? cur.d[bp] : cur.d[7 - bp];
                mark = (cfg_sync_mode == 2'b01) ? cur.f :
                       (cfg_sync_mode == 2'b10) ? cur.l : 1'b0;
                ms   = mark && (cfg_sync_full || bp == 0);
                if (pos == 31) begin
                    if (qfull && tx_en) begin
                        for (int k = 0; k < 4; k++) sh[k] = fq.pop_front();
                        pos = 0;
                    end else begin
                        act = 0;
                    end
                end else begin
                    pos++;
                end
            end else begin
                ms = 0;
                if (qfull && tx_en) begin
                    for (int k = 0; k < 4; k++) sh[k] = fq.pop_front();
                    act = 1;
                    pos = 0;
                end
            end
            if (acc) fq.push_back(src.pop_front());
            enp = tx_en;
        end
    end

    task automatic check(input string req, input string what, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%0b exp=%0b at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare away from the edge, then present the next byte of the source.
    always @(negedge clk) begin
        if (rst_n) begin
            check(tag,  "ser_d",      ser_d,      md);
            check(tag,  "ser_sync",   ser_sync,   ms);
            check("R2", "data_avail", data_avail, fq.size() == 4);
            check("R2", "in_ready",   in_ready,   fq.size() < 4);
            check("R8", "proto_err",  proto_err,  err);
        end
        in_valid = (src.size() > 0);
        if (src.size() > 0) begin
            in_data  = src[0].d;
            in_first = src[0].f;
            in_last  = src[0].l;
        end
    end

    task automatic send_pkt(input int len, input int seed);
        ent_t e;
        for (int i = 0; i < len; i++) begin
            e.d = 8'((seed + i * 37) & 8'hFF);
            e.f = (i == 0);
            e.l = (i == len - 1);
            src.push_back(e);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(4);
        #1 rst_n = 1'b1;
        @(negedge clk); #0.5;
        // R1: reset values
        check("R1", "ser_d",      ser_d,      1'b0);
        check("R1", "ser_sync",   ser_sync,   1'b0);
        check("R1", "data_avail", data_avail, 1'b0);
        check("R1", "in_ready",   in_ready,   1'b1);
        check("R1", "proto_err",  proto_err,  1'b0);

        // R3/R6: stage with enable low, line must hold, then start
        tag = "R6";
        send_pkt(8, 8'h10);
        run(12);
        #0.5 check("R2", "stage full with enable low", data_avail, 1'b1);
        tag = "R3";
        tx_en = 1'b1;
        run(90);

        // R5/R4: back-to-back quadlets, LSB first, last-byte narrow mark
        tag = "R5";
        cfg_sync_mode = 2'b10; cfg_sync_full = 1'b0; cfg_lsb_first = 1'b1;
        send_pkt(12, 8'h5A);
        send_pkt(4, 8'hC3);
        run(150);

        // R4/R10: MSB first, first-byte mark across a packet of odd length
        tag = "R10";
        cfg_sync_mode = 2'b01; cfg_sync_full = 1'b1; cfg_lsb_first = 1'b0;
        send_pkt(5, 8'h81);
        send_pkt(7, 8'h2E);
        run(120);

        // R9: marking off and reserved code
        tag = "R9";
        cfg_sync_mode = 2'b00;
        send_pkt(8, 8'h99);
        run(80);
        cfg_sync_mode = 2'b11;
        send_pkt(8, 8'h44);
        run(80);

        // R7/R8: drop enable mid-quadlet; shifting continues, error latches
        tag = "R7";
        cfg_sync_mode = 2'b10; cfg_sync_full = 1'b1;
        send_pkt(16, 8'h3C);
        run(10);
        tx_en = 1'b0;
        run(70);
        #0.5 check("R8", "error after mid-quadlet drop", proto_err, 1'b1);
        tx_en = 1'b1;
        run(160);

        // R4: leftover stream drained, enable kept high
        tag = "R4";
        cfg_lsb_first = 1'b1;
        send_pkt(8, 8'hF0);
        run(100);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule